// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Status Buffer

This block turns an asynchronous serial line into parallel characters. A tick input from an external baud divider runs at sixteen times the bit rate, and the block samples the line with it. A frame carries 5 to 9 data bits, least significant bit first. An even or odd parity bit may follow, then one or two stop bits. Each finished character lands in a two-entry first-in first-out buffer. One more finished character can wait in a holding stage behind the buffer.

Every buffered character keeps its own frame-error, parity-error and overflow status. The read side always shows the oldest unread character with its status. The ninth data bit comes out on its own pin. Pulsing the pop input removes the oldest entry, so the ninth bit must be taken before the pop. A receive-complete flag reports a non-empty buffer. A receive interrupt request follows that flag whenever a 2-bit priority field is non-zero.

Top module: `serial_rx_top`

## Requirements
- R1: The data width is taken from `cfg_bits`, clamped to the range 5..9. Data is collected least significant bit first and presented right-aligned, with all unreceived upper bits at zero. The low eight bits appear on `rd_data` and bit 8 appears on `rd_bit9`.
- R2: A start is recognised only on a high-to-low transition of the line, seen on a tick. The transition is accepted only if the line is still low on the 8th tick, counting the detecting tick as the first. A shorter low pulse produces no character. Every later bit is sampled 16 ticks after the previous sample.
- R3: Characters are read in arrival order. The buffer holds two characters, and a third may wait in the holding stage without loss. A pop while the buffer is empty changes nothing.
- R4: `st_ferr` is 1 when the first stop bit of the head character sampled low, and 0 when it sampled high. A second stop bit is never checked.
- R5: `cfg_parity[1]` = 1 enables a parity bit after the data. `cfg_parity[0]` = 0 selects even parity and 1 selects odd parity. A mismatch sets `st_perr` for that character. With `cfg_parity[1]` = 0 no parity bit is expected and `st_perr` reads 0.
- R6: An overflow occurs when a start is accepted while both buffer entries are full and a character waits in the holding stage. The waiting character is discarded and the buffered ones are kept. `st_ovf` is set on the next character that enters the buffer.
- R7: The status outputs belong to the head character. They stay unchanged until that character is popped. While the buffer is empty, all data and status outputs read 0.
- R8: In 9-bit operation the ninth data bit of the head character is on `rd_bit9` until that character is popped.
- R9: `st_rxc` is 1 exactly while the buffer holds at least one character. `irq_rxc` equals `st_rxc` when `cfg_rxc_level` is non-zero, and is 0 when the level is 0.
- R10: A synchronous active-high `rst` empties the buffer and the holding stage, clears pending overflow and returns the receiver to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| cfg_bits | input | 4 | Number of data bits (5..9, clamped) |
| cfg_parity | input | 2 | Bit 1 enables parity; bit 0 selects odd (1) or even (0) |
| cfg_two_stop | input | 1 | Expect a second stop bit |
| cfg_rxc_level | input | 2 | Receive interrupt level; 0 disables |
| rd_pop | input | 1 | Remove the head character |
| rd_data | output | 8 | Low eight data bits of the head character |
| rd_bit9 | output | 1 | Ninth data bit of the head character |
| st_ferr | output | 1 | Head character had a low first stop bit |
| st_perr | output | 1 | Head character failed the parity check |
| st_ovf | output | 1 | A character was lost just before the head character |
| st_rxc | output | 1 | Buffer not empty |
| irq_rxc | output | 1 | Receive interrupt request |

## Verification
The assertions assume that `cfg_bits`, `cfg_parity` and `cfg_two_stop` stay constant while a frame is in progress. They also assume `os_tick` is a single-cycle strobe. The head-stability property further assumes that nothing but a pop moves the head. The stimulus changes configuration only while the line is idle, between frames. It drives whole bits of exactly sixteen ticks. Its only deliberately short low pulse is the start glitch, which keeps the line otherwise settled around every mid-bit sample.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int MAX_BITS = 9;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_t;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                ferr;
        logic                perr;
    } rx_frame_t;

    typedef struct packed {
        rx_frame_t frame;
        logic      ovf;
    } rx_entry_t;

    function automatic logic [3:0] clamp_bits(input logic [3:0] req);
        if (req < 4'(MIN_BITS))      return 4'(MIN_BITS);
        else if (req > 4'(MAX_BITS)) return 4'(MAX_BITS);
        else                         return req;
    endfunction

    function automatic logic [MAX_BITS-1:0] align_data(input logic [MAX_BITS-1:0] sh,
                                                       input logic [3:0] nb);
        return sh >> (4'(MAX_BITS) - nb);
    endfunction

endpackage

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx,
    input  logic [3:0] cfg_bits,
    input  logic [1:0] cfg_parity,
    input  logic      cfg_two_stop,
    output logic      start_ok,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

    rx_state_t           state;
    logic [CW-1:0]       cnt;
    logic [3:0]          idx;
    logic [MAX_BITS-1:0] sh;
    logic                par_bit;
    logic                prev;
    logic [3:0]          nb;
    logic [MAX_BITS-1:0] aligned;

    assign nb      = clamp_bits(cfg_bits);
    assign aligned = align_data(sh, nb);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            sh       <= '0;
            par_bit  <= 1'b0;
            prev     <= 1'b1;
            start_ok <= 1'b0;
            done     <= 1'b0;
            frame    <= '0;
        end else begin
            start_ok <= 1'b0;
            done     <= 1'b0;
            if (tick) begin
                prev <= rx;
                unique case (state)
                    ST_IDLE: begin
                        if (!rx && prev) begin
                            state <= ST_START;
                            cnt   <= CW'(1);
                        end
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            idx <= '0;
                            if (!rx) begin
                                state    <= ST_DATA;
                                start_ok <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt <= '0;
                            sh  <= {rx, sh[MAX_BITS-1:1]};
                            if (idx == nb - 4'd1) state <= cfg_parity[1] ? ST_PAR : ST_STOP;
                            else                  idx   <= idx + 4'd1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            par_bit <= rx;
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt        <= '0;
                            done       <= 1'b1;
                            frame.data <= aligned;
                            frame.ferr <= !rx;
                            frame.perr <= cfg_parity[1] & ((^aligned) ^ par_bit ^ cfg_parity[0]);
                            state      <= cfg_two_stop ? ST_STOP2 : ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_rx_buf.sv
module serial_rx_buf
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int FW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  rx_entry_t     push_item,
    input  logic          pop,
    output rx_entry_t     head,
    output logic [FW-1:0] fill,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_entry_t       mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic            do_pop, do_push;

    assign empty   = (fill == '0);
    assign full    = (fill == FW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_item;
                wr_ptr      <= step(wr_ptr);
            end
            if (do_pop) rd_ptr <= step(rd_ptr);
            if (do_push && !do_pop)      fill <= fill + 1'b1;
            else if (do_pop && !do_push) fill <= fill - 1'b1;
        end
    end

endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
    import serial_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 2,
    parameter int SYNC  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rx_in,
    input  logic [3:0] cfg_bits,
    input  logic [1:0] cfg_parity,
    input  logic       cfg_two_stop,
    input  logic [1:0] cfg_rxc_level,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rd_bit9,
    output logic       st_ferr,
    output logic       st_perr,
    output logic       st_ovf,
    output logic       st_rxc,
    output logic       irq_rxc
);
    localparam int FW = $clog2(DEPTH + 1);

    logic [SYNC-1:0] sync_q;
    logic            rx_s;
    logic            start_ok, frame_done;
    rx_frame_t       frame;
    rx_entry_t       hold, head;
    logic            hold_valid, pend_ovf;
    logic            move, ovf_event;
    logic [FW-1:0]   fill;
    logic            full, empty;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC-2:0], rx_in};
    end
    assign rx_s = sync_q[SYNC-1];

    serial_rx_frame #(.OSR(OSR)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .tick        (os_tick),
        .rx          (rx_s),
        .cfg_bits    (cfg_bits),
        .cfg_parity  (cfg_parity),
        .cfg_two_stop(cfg_two_stop),
        .start_ok    (start_ok),
        .done        (frame_done),
        .frame       (frame)
    );

    assign move      = hold_valid && (!full || rd_pop);
    assign ovf_event = start_ok && hold_valid && !move;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold       <= '0;
            hold_valid <= 1'b0;
            pend_ovf   <= 1'b0;
        end else begin
            if (ovf_event) begin
                hold_valid <= 1'b0;
                pend_ovf   <= 1'b1;
            end else if (move) begin
                hold_valid <= 1'b0;
            end
            if (frame_done) begin
                hold.frame <= frame;
                hold.ovf   <= pend_ovf;
                hold_valid <= 1'b1;
                pend_ovf   <= 1'b0;
            end
        end
    end

    serial_rx_buf #(.DEPTH(DEPTH), .FW(FW)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .push     (move),
        .push_item(hold),
        .pop      (rd_pop),
        .head     (head),
        .fill     (fill),
        .full     (full),
        .empty    (empty)
    );

    assign rd_data = empty ? 8'h00 : head.frame.data[7:0];
    assign rd_bit9 = !empty && head.frame.data[MAX_BITS-1];
    assign st_ferr = !empty && head.frame.ferr;
    assign st_perr = !empty && head.frame.perr;
    assign st_ovf  = !empty && head.ovf;
    assign st_rxc  = !empty;
    assign irq_rxc = st_rxc && (cfg_rxc_level != 2'b00);

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
    parameter int DEPTH = 2,
    parameter int FW    = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_pop,
    input logic [7:0]    rd_data,
    input logic          rd_bit9,
    input logic          st_ferr,
    input logic          st_perr,
    input logic          st_ovf,
    input logic          st_rxc,
    input logic          irq_rxc,
    input logic [1:0]    cfg_rxc_level,
    input logic [FW-1:0] fill,
    input logic          hold_valid,
    input logic          frame_done,
    input logic          ovf_event
);
    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rxc_level == 2'b00) |-> !irq_rxc);

    // R9
    irq_rxc_chk: assert property (@(posedge clk) disable iff (rst)
        irq_rxc |-> st_rxc);

    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_rxc && !rd_pop) |=> $stable({rd_data, rd_bit9, st_ferr, st_perr, st_ovf}));

    // R3
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && fill == '0 && !hold_valid) |=> (fill == '0));

    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= FW'(DEPTH));

    // R6
    ovf_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_event && !rd_pop) |=> (fill == FW'(DEPTH)));

    // R6
    done_slot_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !hold_valid);
endmodule

bind serial_rx_top serial_rx_chk #(.DEPTH(DEPTH), .FW(FW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_pop       (rd_pop),
    .rd_data      (rd_data),
    .rd_bit9      (rd_bit9),
    .st_ferr      (st_ferr),
    .st_perr      (st_perr),
    .st_ovf       (st_ovf),
    .st_rxc       (st_rxc),
    .irq_rxc      (irq_rxc),
    .cfg_rxc_level(cfg_rxc_level),
    .fill         (fill),
    .hold_valid   (hold_valid),
    .frame_done   (frame_done),
    .ovf_event    (ovf_event)
);

// File: tb/serial_rx_top_tb.sv
module serial_rx_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [3:0] cfg_bits = 4'd8;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic [1:0] cfg_rxc_level = 2'b00;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, st_ferr, st_perr, st_ovf, st_rxc, irq_rxc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int tick_cnt = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
        os_tick  <= (tick_cnt == 3);
    end

    serial_rx_top u_dut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx_in(rx_in),
        .cfg_bits(cfg_bits), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .cfg_rxc_level(cfg_rxc_level), .rd_pop(rd_pop), .rd_data(rd_data),
        .rd_bit9(rd_bit9), .st_ferr(st_ferr), .st_perr(st_perr), .st_ovf(st_ovf),
        .st_rxc(st_rxc), .irq_rxc(irq_rxc)
    );

    typedef struct packed {
        logic [3:0] nb;
        logic [1:0] pm;
        logic       two;
        logic [8:0] d;
        logic       bp;
        logic       bs1;
        logic       bs2;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{4'd8, 2'b00, 1'b0, 9'h0A5, 1'b0, 1'b0, 1'b0},
        '{4'd5, 2'b00, 1'b0, 9'h1F3, 1'b0, 1'b0, 1'b0},
        '{4'd7, 2'b10, 1'b0, 9'h05A, 1'b0, 1'b0, 1'b0},
        '{4'd7, 2'b10, 1'b0, 9'h05A, 1'b1, 1'b0, 1'b0},
        '{4'd6, 2'b11, 1'b1, 9'h02C, 1'b0, 1'b0, 1'b0},
        '{4'd6, 2'b11, 1'b1, 9'h02C, 1'b1, 1'b0, 1'b0},
        '{4'd8, 2'b00, 1'b0, 9'h03C, 1'b0, 1'b1, 1'b0},
        '{4'd8, 2'b00, 1'b1, 9'h0C3, 1'b0, 1'b0, 1'b1},
        '{4'd9, 2'b00, 1'b0, 9'h1A5, 1'b0, 1'b0, 1'b0},
        '{4'd9, 2'b10, 1'b1, 9'h0FF, 1'b0, 1'b0, 1'b0},
        '{4'd8, 2'b00, 1'b0, 9'h081, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) rx_in = b;
        repeat (63) @(negedge clk);
    endtask

    task automatic send_frame(input vec_t v);
        logic [8:0] md;
        md = v.d & 9'((1 << v.nb) - 1);
        send_bit(1'b0);
        for (int i = 0; i < v.nb; i++) send_bit(v.d[i]);
        if (v.pm[1]) send_bit((^md) ^ v.pm[0] ^ v.bp);
        send_bit(!v.bs1);
        if (v.two) send_bit(!v.bs2);
        send_bit(1'b1);
    endtask

    task automatic pop_one();
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
    endtask

    task automatic plain(input logic [7:0] d);
        send_frame('{4'd8, 2'b00, 1'b0, {1'b0, d}, 1'b0, 1'b0, 1'b0});
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] ed;
        do_reset();
        // R10 reset state
        chk("R10 rxc", st_rxc, 0);
        chk("R10 irq", irq_rxc, 0);
        chk("R10 data", {rd_bit9, rd_data}, 0);
        chk("R10 flags", {st_ferr, st_perr, st_ovf}, 0);

        // table: R1 R4 R5 R8
        for (int k = 0; k < NV; k++) begin
            cfg_bits = VEC[k].nb;
            cfg_parity = VEC[k].pm;
            cfg_two_stop = VEC[k].two;
            send_frame(VEC[k]);
            ed = VEC[k].d & 9'((1 << VEC[k].nb) - 1);
            chk("R1 data", rd_data, int'(ed[7:0]));
            chk("R8 bit9", rd_bit9, int'(ed[8]));
            chk("R4 ferr", st_ferr, int'(VEC[k].bs1));
            chk("R5 perr", st_perr, int'(VEC[k].pm[1] & VEC[k].bp));
            chk("R9 rxc set", st_rxc, 1);
            pop_one();
            chk("R9 rxc clear", st_rxc, 0);
        end
        cfg_bits = 4'd8; cfg_parity = 2'b00; cfg_two_stop = 1'b0;

        // R9 interrupt gating
        plain(8'h11);
        chk("R9 irq level0", irq_rxc, 0);
        @(negedge clk) cfg_rxc_level = 2'd2;
        @(negedge clk);
        chk("R9 irq level2", irq_rxc, 1);
        pop_one();
        chk("R9 irq empty", irq_rxc, 0);
        cfg_rxc_level = 2'd0;

        // R2 short glitch rejected
        @(negedge clk) rx_in = 1'b0;
        repeat (16) @(negedge clk);
        rx_in = 1'b1;
        repeat (900) @(negedge clk);
        chk("R2 glitch ignored", st_rxc, 0);
        plain(8'h6E);
        chk("R2 after glitch", rd_data, 8'h6E);
        pop_one();

        // R3 pop on empty ignored
        pop_one();
        chk("R3 pop empty", st_rxc, 0);
        plain(8'h42);
        chk("R3 after empty pop", rd_data, 8'h42);
        pop_one();

        // R3 two buffered plus one waiting, order kept
        plain(8'hA1); plain(8'hB2); plain(8'hC3);
        chk("R3 first", rd_data, 8'hA1);
        pop_one();
        chk("R3 second", rd_data, 8'hB2);
        pop_one();
        chk("R3 third", rd_data, 8'hC3);
        chk("R3 third no ovf", st_ovf, 0);
        pop_one();
        chk("R3 drained", st_rxc, 0);

        // R6 overflow
        plain(8'h01); plain(8'h02); plain(8'h03); plain(8'h04);
        chk("R6 head kept", rd_data, 8'h01);
        chk("R6 head no ovf", st_ovf, 0);
        pop_one();
        chk("R6 second kept", rd_data, 8'h02);
        chk("R6 second no ovf", st_ovf, 0);
        pop_one();
        chk("R6 waiting dropped", rd_data, 8'h04);
        chk("R6 ovf attached", st_ovf, 1);
        pop_one();
        chk("R6 drained", st_rxc, 0);

        // R7 per-entry flags
        send_frame('{4'd8, 2'b00, 1'b0, 9'h055, 1'b0, 1'b1, 1'b0});
        plain(8'h66);
        chk("R7 head ferr", st_ferr, 1);
        repeat (50) @(negedge clk);
        chk("R7 ferr held", st_ferr, 1);
        pop_one();
        chk("R7 next ferr", st_ferr, 0);
        chk("R7 next data", rd_data, 8'h66);
        pop_one();
        chk("R7 empty flags", {st_ferr, st_perr, st_ovf, rd_data}, 0);

        // R10 reset mid-stream
        plain(8'h77); plain(8'h88);
        do_reset();
        chk("R10 reset empties", st_rxc, 0);
        plain(8'h99);
        chk("R10 after reset", rd_data, 8'h99);
        chk("R10 no stale ovf", st_ovf, 0);
        pop_one();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule